// File: doc/BRIEF.md
# XGMII Transmit Framer with Minimum-Length Padding

This block converts a client frame stream into a 32-bit XGMII transmit column stream. The client presents 32-bit payload words with a per-lane keep mask, a last flag, an underrun flag and a precomputed 32-bit frame check sequence (FCS) that is valid with the last word. The block opens every frame with a start column and a preamble/SFD column, forwards payload words unchanged, zero-pads payloads shorter than the minimum, appends the FCS, and closes with an end code followed by idle fill.

The tail of a frame (remaining payload lanes, pad bytes, FCS bytes, end code and idle lanes) is handled as one byte stream that is packed lane by lane into columns, so each part begins in the lane right after the part before it, whatever lane that is. The client is held off with `ready_o` whenever the block is emitting anything other than payload words. After each frame the block sends a minimum run of idle columns before it can start the next one.

Top module: `xgmii_tx_framer`

## Requirements
- R1: Outside a frame every column is an idle column: data 0x07070707, control 4'b1111.
- R2: A frame starts with data 0x555555FB / control 4'b0001, and the next column is data 0xD5555555 / control 4'b0000.
- R3: Every payload word except the last is sent unchanged in the column after it is accepted, with control 4'b0000. A last word contributes only the lanes set in `keep_i`, which are contiguous from lane 0 (4'b0001, 4'b0011, 4'b0111 or 4'b1111); bit n of `keep_i` flags lane n, which is data bits [8n+7:8n].
- R4: A payload shorter than MIN_LEN (60) bytes is followed by zero bytes with control 0 until it is MIN_LEN bytes long; longer payloads get no pad.
- R5: The four FCS bytes follow the last payload or pad byte at once, `fcs_i[31:24]` first and `fcs_i[7:0]` last, with control 0, continuing in lane 0 of the next column when lanes run out.
- R6: The lane after the last FCS byte carries the end code with its control bit set: 0xFE when the frame's `underrun_i` was 1, otherwise 0xFD.
- R7: Every lane after the end code in the same column carries 0x07 with its control bit set.
- R8: At least GAP_COLS (3) full idle columns lie between the column holding one frame's end code and the next start column; reset counts as such a gap.
- R9: `ready_o` is high only while the block can accept a payload word: it is low while the start column is formed and from the acceptance of the last word until the next frame's preamble column is on the output.
- R10: When the last FCS byte falls in lane 3, the end code goes in lane 0 of a new column whose lanes 1 to 3 are idle fill.
- R11: During and right after reset the output is an idle column and `ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Column clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Client word present |
| data_i | input | 32 | Payload word, lane 0 in bits [7:0] |
| keep_i | input | 4 | Valid lanes of the word, contiguous from lane 0 |
| last_i | input | 1 | Word is the last of the frame |
| underrun_i | input | 1 | Frame underran; selects the error end code (with last word) |
| fcs_i | input | 32 | Frame check sequence (with last word) |
| ready_o | output | 1 | Word on the client inputs is taken at this edge |
| xd_o | output | 32 | XGMII transmit data column |
| xc_o | output | 4 | XGMII transmit control bits, one per lane |

## Verification
The assertions assume a client that, once a frame has begun, keeps `valid_i` high until its last word is taken, sets all four keep bits on every word but the last, and never sends a zero keep mask; the checker states the first of these as its own property. The bench sweeps every payload length from 1 to 72 bytes, so every lane position of the last payload byte, pad, FCS and end code is reached both below and above the minimum. Underrun and non-underrun frames are mixed, and the idle time the client leaves between frames runs from none to three columns so that requests that arrive during the gap are held off.

// File: rtl/xgmii_tx_pkg.sv
package xgmii_tx_pkg;

  localparam logic [31:0] IDLE_COL  = 32'h0707_0707;
  localparam logic [31:0] START_COL = 32'h5555_55FB;
  localparam logic [31:0] SFD_COL   = 32'hD555_5555;
  localparam logic [7:0]  IDLE_CH   = 8'h07;
  localparam logic [7:0]  TERM_CH   = 8'hFD;
  localparam logic [7:0]  ERR_CH    = 8'hFE;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_TAIL,
    ST_GAP
  } tx_state_e;

  function automatic logic [2:0] count_lanes(input logic [3:0] keep);
    logic [2:0] n;
    n = '0;
    for (int i = 0; i < 4; i++) n = n + {2'b00, keep[i]};
    return n;
  endfunction

endpackage

// File: rtl/xgmii_tx_len.sv
// Payload byte counter (saturating at MIN_LEN) and pad length for a last word.
module xgmii_tx_len
  import xgmii_tx_pkg::*;
#(
  parameter int MIN_LEN = 60,
  parameter int CW      = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          take_i,
  input  logic [3:0]    keep_i,
  output logic [CW-1:0] pad_o
);

  localparam logic [CW-1:0] MIN_W = CW'(MIN_LEN);

  logic [CW-1:0] cnt_q, sum;

  always_comb begin
    sum   = cnt_q + CW'(count_lanes(keep_i));
    pad_o = (sum >= MIN_W) ? '0 : MIN_W - sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (take_i)  cnt_q <= (sum >= MIN_W) ? MIN_W : sum;
  end

endmodule

// File: rtl/xgmii_tx_lane.sv
// One output lane of a tail column: carried payload, pad, FCS, end code or fill.
module xgmii_tx_lane
  import xgmii_tx_pkg::*;
#(
  parameter int LANE = 0,
  parameter int TW   = 8
) (
  input  logic [2:0]    fill_i,
  input  logic [7:0]    carry_i,
  input  logic [TW-1:0] pos_i,
  input  logic [TW-1:0] pad_i,
  input  logic [31:0]   fcs_i,
  input  logic          err_i,
  output logic [7:0]    byte_o,
  output logic          ctrl_o
);

  logic [TW-1:0] k, rel;

  always_comb begin
    // k: index of this lane's byte within the tail stream
    k      = pos_i + TW'(LANE) - TW'(fill_i);
    rel    = k - pad_i;
    byte_o = 8'h00;
    ctrl_o = 1'b0;
    if (fill_i > 3'(LANE)) begin
      byte_o = carry_i;
    end else if (k >= pad_i) begin
      if (rel < TW'(4)) begin
        case (rel[1:0])
          2'd0:    byte_o = fcs_i[31:24];
          2'd1:    byte_o = fcs_i[23:16];
          2'd2:    byte_o = fcs_i[15:8];
          default: byte_o = fcs_i[7:0];
        endcase
      end else if (rel == TW'(4)) begin
        byte_o = err_i ? ERR_CH : TERM_CH;
        ctrl_o = 1'b1;
      end else begin
        byte_o = IDLE_CH;
        ctrl_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xgmii_tx_framer.sv
module xgmii_tx_framer
  import xgmii_tx_pkg::*;
#(
  parameter int MIN_LEN  = 60,
  parameter int GAP_COLS = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] data_i,
  input  logic [3:0]  keep_i,
  input  logic        last_i,
  input  logic        underrun_i,
  input  logic [31:0] fcs_i,
  output logic        ready_o,
  output logic [31:0] xd_o,
  output logic [3:0]  xc_o
);

  localparam int LANES = 4;
  localparam int CW    = $clog2(MIN_LEN + 5);
  localparam int TW    = CW + 1;
  localparam int GW    = $clog2(GAP_COLS + 1);

  tx_state_e     state_q, state_d;
  logic [TW-1:0] pos_q, pos_d;
  logic [TW-1:0] pad_q, pad_d;
  logic [31:0]   fcs_q;
  logic          err_q;
  logic [GW-1:0] gap_q;

  logic [31:0]   col_d;
  logic [3:0]    ctl_d;
  logic          take, first_tail, end_here;
  logic [CW-1:0] pad_w;
  logic [2:0]    fill;
  logic [TW-1:0] pos_in, pad_in;
  logic [31:0]   fcs_in;
  logic          err_in;
  logic [31:0]   tail_d;
  logic [3:0]    tail_c;

  assign ready_o    = (state_q == ST_DATA);
  assign take       = ready_o && valid_i;
  assign first_tail = take && last_i;

  xgmii_tx_len #(.MIN_LEN(MIN_LEN), .CW(CW)) i_len (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(state_q == ST_PRE),
    .take_i (take),
    .keep_i (keep_i),
    .pad_o  (pad_w)
  );

  // The last word's tail column uses live inputs; later columns use the latched copy.
  always_comb begin
    fill   = first_tail ? count_lanes(keep_i) : 3'd0;
    pos_in = first_tail ? '0 : pos_q;
    pad_in = first_tail ? TW'(pad_w) : pad_q;
    fcs_in = first_tail ? fcs_i : fcs_q;
    err_in = first_tail ? underrun_i : err_q;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xgmii_tx_lane #(.LANE(l), .TW(TW)) i_lane (
      .fill_i (fill),
      .carry_i(data_i[8*l +: 8]),
      .pos_i  (pos_in),
      .pad_i  (pad_in),
      .fcs_i  (fcs_in),
      .err_i  (err_in),
      .byte_o (tail_d[8*l +: 8]),
      .ctrl_o (tail_c[l])
    );
  end

  // End code index (pad + 4) lies within this column's tail lanes
  assign end_here = (pad_in + TW'(4) + TW'(fill)) <= (pos_in + TW'(3));

  always_comb begin
    state_d = state_q;
    col_d   = IDLE_COL;
    ctl_d   = 4'b1111;
    pos_d   = pos_q;
    pad_d   = pad_q;
    case (state_q)
      ST_IDLE: if (valid_i) begin
        state_d = ST_PRE;
        col_d   = START_COL;
        ctl_d   = 4'b0001;
      end
      ST_PRE: begin
        state_d = ST_DATA;
        col_d   = SFD_COL;
        ctl_d   = 4'b0000;
      end
      ST_DATA: if (valid_i) begin
        if (last_i) begin
          col_d   = tail_d;
          ctl_d   = tail_c;
          pos_d   = TW'(4) - TW'(fill);
          pad_d   = pad_in;
          state_d = end_here ? ST_GAP : ST_TAIL;
        end else begin
          col_d = data_i;
          ctl_d = 4'b0000;
        end
      end
      ST_TAIL: begin
        col_d   = tail_d;
        ctl_d   = tail_c;
        pos_d   = pos_q + TW'(4);
        state_d = end_here ? ST_GAP : ST_TAIL;
      end
      ST_GAP: if (gap_q == GW'(GAP_COLS - 1)) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      xd_o    <= IDLE_COL;
      xc_o    <= 4'b1111;
      pos_q   <= '0;
      pad_q   <= '0;
      fcs_q   <= '0;
      err_q   <= 1'b0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      xd_o    <= col_d;
      xc_o    <= ctl_d;
      pos_q   <= pos_d;
      pad_q   <= pad_d;
      if (first_tail) begin
        fcs_q <= fcs_i;
        err_q <= underrun_i;
      end
      gap_q <= (state_q == ST_GAP) ? gap_q + GW'(1) : '0;
    end
  end

endmodule

// File: rtl/xgmii_tx_framer_chk.sv
module xgmii_tx_framer_chk
  import xgmii_tx_pkg::*;
#(
  parameter int GAP_COLS = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] data_i,
  input logic        last_i,
  input logic        ready_o,
  input logic [31:0] xd_o,
  input logic [3:0]  xc_o
);

  localparam int GW = $clog2(GAP_COLS + 1);

  logic [GW-1:0] idle_run;
  logic          is_idle, is_start;

  assign is_idle  = (xc_o == 4'b1111) && (xd_o == IDLE_COL);
  assign is_start = (xc_o == 4'b0001) && (xd_o == START_COL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             idle_run <= GW'(GAP_COLS);
    else if (!is_idle)                       idle_run <= '0;
    else if (idle_run != GW'(GAP_COLS))      idle_run <= idle_run + GW'(1);
  end

  // R1
  idle_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xc_o == 4'b1111) |-> (xd_o == IDLE_COL ||
      (xd_o[31:8] == 24'h070707 && (xd_o[7:0] == TERM_CH || xd_o[7:0] == ERR_CH))));

  // R2
  start_sfd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_start |=> (xc_o == 4'b0000 && xd_o == SFD_COL));

  // R3
  data_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && valid_i && !last_i) |=> (xc_o == 4'b0000 && xd_o == $past(data_i)));

  // R7
  ctrl_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xc_o inside {4'b0000, 4'b0001, 4'b1000, 4'b1100, 4'b1110, 4'b1111});

  // R8
  gap_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_start |-> (idle_run == GW'(GAP_COLS)));

  // R9
  ready_ctrl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (xc_o == 4'b0000));

  // R9: client contract, valid held for the whole frame
  client_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> valid_i);

  // R11
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (is_idle && !ready_o));

endmodule

bind xgmii_tx_framer xgmii_tx_framer_chk #(.GAP_COLS(GAP_COLS)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .data_i (data_i),
  .last_i (last_i),
  .ready_o(ready_o),
  .xd_o   (xd_o),
  .xc_o   (xc_o)
);

// File: tb/test_xgmii_tx_framer.sv
`timescale 1ns/1ps
module test_xgmii_tx_framer;

  localparam int MIN_LEN = 60;
  localparam int GAP     = 3;
  localparam int MAX_LEN = 72;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [3:0]  keep_i = '0;
  logic        last_i = 1'b0;
  logic        underrun_i = 1'b0;
  logic [31:0] fcs_i = '0;
  logic        ready_o;
  logic [31:0] xd_o;
  logic [3:0]  xc_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xgmii_tx_framer #(.MIN_LEN(MIN_LEN), .GAP_COLS(GAP)) i_xgmii_tx_framer (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .keep_i(keep_i), .last_i(last_i), .underrun_i(underrun_i), .fcs_i(fcs_i),
    .ready_o(ready_o), .xd_o(xd_o), .xc_o(xc_o)
  );

  function automatic logic [7:0] pay(int len, int b);
    return 8'(len * 7 + b * 13 + 1);
  endfunction
  function automatic logic [31:0] fcs_of(int len);
    return {8'(len), 8'(~len), 8'hA5, 8'(len * 3)};
  endfunction
  function automatic bit err_of(int len);
    return (len % 3) == 0;
  endfunction

  // Expected byte, control bit and requirement tag at tail-stream index b
  task automatic exp_byte(input int len, input int b, output logic [7:0] d,
                          output logic c, output string tag);
    int lp;
    logic [31:0] f;
    lp = (len > MIN_LEN) ? len : MIN_LEN;
    f  = fcs_of(len);
    c  = 1'b0;
    if (b < len) begin d = pay(len, b); tag = "R3"; end
    else if (b < lp) begin d = 8'h00; tag = "R4"; end
    else if (b < lp + 4) begin d = f[8*(3-(b-lp)) +: 8]; tag = "R5"; end
    else if (b == lp + 4) begin
      d = err_of(len) ? 8'hFE : 8'hFD; c = 1'b1;
      tag = ((b % 4) == 0) ? "R10" : "R6";
    end else begin d = 8'h07; c = 1'b1; tag = "R7"; end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send_frame(input int len);
    int nw;
    nw = (len + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      for (int l = 0; l < 4; l++) begin
        data_i[8*l +: 8] = (4*w + l < len) ? pay(len, 4*w + l) : 8'h00;
        keep_i[l]        = (4*w + l < len);
      end
      last_i     = (w == nw - 1);
      underrun_i = err_of(len);
      fcs_i      = fcs_of(len);
      valid_i    = 1'b1;
      while (!ready_o) @(negedge clk);
      @(negedge clk);
    end
    valid_i = 1'b0;
    last_i  = 1'b0;
  endtask

  // Driver
  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int len = 1; len <= MAX_LEN; len++) begin
      send_frame(len);
      repeat (len % 4) @(negedge clk);
    end
  end

  // Monitor
  initial begin
    int idle;
    repeat (2) @(negedge clk);
    // R11
    check(xd_o == 32'h07070707 && xc_o == 4'hF && !ready_o, "R11", "reset column",
          {xc_o, xd_o}, {4'hF, 32'h07070707});
    @(posedge rst_ni);
    idle = GAP;
    for (int len = 1; len <= MAX_LEN; len++) begin
      int lp, ncol, nw;
      lp   = (len > MIN_LEN) ? len : MIN_LEN;
      ncol = (lp + 5 + 3) / 4;
      nw   = (len + 3) / 4;
      forever begin
        @(negedge clk);
        if (xc_o == 4'b0001 && xd_o == 32'h555555FB) break;
        // R1
        check(xc_o == 4'hF && xd_o == 32'h07070707, "R1", "idle column",
              {xc_o, xd_o}, {4'hF, 32'h07070707});
        idle++;
      end
      // R8
      check(idle >= GAP, "R8", "idle columns before start", 36'(idle), 36'(GAP));
      // R9
      check(!ready_o, "R9", "ready at start column", 36'(ready_o), 36'd0);
      @(negedge clk);
      // R2
      check(xc_o == 4'h0 && xd_o == 32'hD5555555, "R2", "preamble column",
            {xc_o, xd_o}, {4'h0, 32'hD5555555});
      for (int j = 0; j < ncol; j++) begin
        logic [31:0] ed;
        logic [3:0]  ec;
        string tag, t;
        bit found;
        @(negedge clk);
        tag = "R3";
        found = 1'b0;
        for (int l = 0; l < 4; l++) begin
          logic [7:0] d;
          logic c;
          exp_byte(len, 4*j + l, d, c, t);
          ed[8*l +: 8] = d;
          ec[l] = c;
          if (!found && (xd_o[8*l +: 8] !== d || xc_o[l] !== c)) begin
            tag = t;
            found = 1'b1;
          end
        end
        check(xd_o === ed && xc_o === ec, tag, $sformatf("len %0d column %0d", len, j),
              {xc_o, xd_o}, {ec, ed});
        // R9
        check(ready_o == (j < nw - 1), "R9", $sformatf("ready len %0d column %0d", len, j),
              36'(ready_o), 36'(j < nw - 1));
      end
      idle = 0;
    end
    repeat (GAP + 2) begin
      @(negedge clk);
      // R1
      check(xc_o == 4'hF && xd_o == 32'h07070707, "R1", "trailing idle",
            {xc_o, xd_o}, {4'hF, 32'h07070707});
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule